// File: doc/BRIEF.md
# Audio Frame-Clock Synchronization Guard

This block sits in the system-clock domain next to a slave-mode audio serial port. The port's frame clock is expected to keep a fixed period, counted in system clocks. The block brings the frame clock in through a two-flop synchronizer and measures the number of system clocks between successive rising edges. It compares that count against a stored reference period. Tolerances are given in bit-clock periods and converted to system clocks through the `SYS_PER_BCK` parameter (4 for a 256x system clock with a 64x bit clock).

A large jump in the period means synchronization is lost. The block then drives three mute controls:

- one that holds the DAC data path at midscale,
- one that forces the ADC output word to zero code,
- one that holds the serial audio output line low.

Recovery has two steps. First a fresh reference is captured and confirmed by two consecutive matching frames, which raises `locked`. Then the mutes stay asserted for a further fixed number of frames before normal data is released. Every output changes only at a synchronized frame boundary, so a word is never cut in the middle.

Top module: `audio_sync_guard`

## Requirements
- R1: While reset is asserted and directly after it, `mute_dac`, `zero_adc` and `douts_force_low` are 1 and `locked` is 0.
- R2: The first measured period (the second rising edge after reset) becomes the reference. `locked` rises once two consecutive periods each lie within ±RELOCK_BCK·SYS_PER_BCK system clocks (±4 by default) of that reference.
- R3: While unlocked, any period outside the relock window replaces the reference and restarts the count of matching periods. A deviation of 5 bit clocks (20 system clocks) therefore never counts towards relock.
- R4: After `locked` rises, the three mute outputs stay 1 for exactly RELEASE_FRAMES (32) frames, counted from the frame in which `locked` rose. They drop to 0 together at the next frame boundary.
- R5: While locked, a period deviation of up to and including TRIP_BCK (6) bit clocks, that is 24 system clocks, changes no output.
- R6: While locked, a period deviating by more than 24 system clocks drops `locked` and asserts all mutes at that frame boundary. That period becomes the new reference.
- R7: A loss detected during the release countdown also drops `locked`. The full relock and 32-frame release sequence then restarts.
- R8: `mute_dac`, `zero_adc` and `douts_force_low` are always equal. They are 0 only while locked and after the release countdown.
- R9: Outputs change only in the cycle after a synchronized frame-clock rising edge. Within a frame they hold one value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrck_in | input | 1 | Frame clock from the serial audio port |
| mute_dac | output | 1 | 1: force DAC path to midscale |
| zero_adc | output | 1 | 1: force ADC output word to zero code |
| douts_force_low | output | 1 | 1: hold serial audio output low |
| locked | output | 1 | 1: frame timing confirmed synchronous |

## Verification
Two events can fall on the same frame edge, and the bench provokes each case on purpose.

- **Loss during the release countdown.** A release-countdown step and a loss detection can both land on one frame edge. The bench stretches a frame by 44 system clocks while the countdown is running. Correct behaviour is that the loss wins: `locked` drops and the release restarts with a full 32 frames.
- **Rejected candidate during relock.** Reference recapture and the confirmation count also coincide while relocking. A 5-bit-clock frame is inserted right after the first matching frame. It must both reset the count and become the new reference, which is judged by the exact frame in which `locked` finally rises.

// File: rtl/audio_sync_guard.sv
module audio_sync_guard #(
  parameter int SYS_PER_BCK    = 4,
  parameter int TRIP_BCK       = 6,
  parameter int RELOCK_BCK     = 1,
  parameter int RELEASE_FRAMES = 32,
  parameter int CNT_W          = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lrck_in,
  output logic mute_dac,
  output logic zero_adc,
  output logic douts_force_low,
  output logic locked
);
  localparam int TRIP_CLK = TRIP_BCK * SYS_PER_BCK;
  localparam int NEAR_CLK = RELOCK_BCK * SYS_PER_BCK;
  localparam int REL_W    = (RELEASE_FRAMES > 1) ? $clog2(RELEASE_FRAMES) : 1;
  localparam logic [CNT_W-1:0] TRIP_LIM = CNT_W'(TRIP_CLK);
  localparam logic [CNT_W-1:0] NEAR_LIM = CNT_W'(NEAR_CLK);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [REL_W-1:0] REL_LAST = REL_W'(RELEASE_FRAMES - 1);

  typedef enum logic [1:0] {ST_ACQ, ST_CHECK, ST_RELEASE, ST_RUN} st_t;

  st_t              state;
  logic [2:0]       lr_sync;
  logic             rise, seen, good, trip, near;
  logic [CNT_W-1:0] cnt, ref_len, diff;
  logic [REL_W-1:0] rel_cnt;

  assign rise = lr_sync[1] & ~lr_sync[2];
  assign diff = (cnt >= ref_len) ? cnt - ref_len : ref_len - cnt;
  assign trip = diff > TRIP_LIM;
  assign near = diff <= NEAR_LIM;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lr_sync <= '0;
      cnt     <= '0;
      seen    <= 1'b0;
    end else begin
      lr_sync <= {lr_sync[1:0], lrck_in};
      if (rise) begin
        cnt  <= CNT_W'(1);
        seen <= 1'b1;
      end else if (cnt != CNT_MAX) begin
        cnt <= cnt + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state   <= ST_ACQ;
      ref_len <= '0;
      good    <= 1'b0;
      rel_cnt <= '0;
    end else if (rise && seen) begin
      case (state)
        ST_ACQ: begin
          ref_len <= cnt;
          good    <= 1'b0;
          state   <= ST_CHECK;
        end
        ST_CHECK:
          if (!near) begin
            ref_len <= cnt;
            good    <= 1'b0;
          end else if (good) begin
            good    <= 1'b0;
            rel_cnt <= '0;
            state   <= ST_RELEASE;
          end else begin
            good <= 1'b1;
          end
        ST_RELEASE:
          if (trip) begin
            ref_len <= cnt;
            good    <= 1'b0;
            state   <= ST_CHECK;
          end else if (rel_cnt == REL_LAST) begin
            state <= ST_RUN;
          end else begin
            rel_cnt <= rel_cnt + 1'b1;
          end
        ST_RUN:
          if (trip) begin
            ref_len <= cnt;
            good    <= 1'b0;
            state   <= ST_CHECK;
          end
        default: state <= ST_ACQ;
      endcase
    end

  assign locked          = (state == ST_RELEASE) || (state == ST_RUN);
  assign mute_dac        = (state != ST_RUN);
  assign zero_adc        = mute_dac;
  assign douts_force_low = mute_dac;
endmodule

// File: rtl/audio_sync_guard_chk.sv
module audio_sync_guard_chk #(
  parameter int CNT_W    = 12,
  parameter int TRIP_CLK = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rise,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] ref_len,
  input logic             mute_dac,
  input logic             zero_adc,
  input logic             douts_force_low,
  input logic             locked
);
  logic [CNT_W:0] gap;
  assign gap = (cnt > ref_len) ? {1'b0, cnt} - {1'b0, ref_len} : {1'b0, ref_len} - {1'b0, cnt};

  a_r8_mutes_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_dac == zero_adc) && (zero_adc == douts_force_low));

  a_r8_unmute_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    !mute_dac |-> locked);

  a_r9_frame_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable({mute_dac, locked}));

  a_r2_lock_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(rise));

  a_r6_trip_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && locked && (gap > (CNT_W+1)'(TRIP_CLK))) |=> !locked);
endmodule

bind audio_sync_guard audio_sync_guard_chk #(.CNT_W(CNT_W), .TRIP_CLK(TRIP_CLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .rise(rise), .cnt(cnt), .ref_len(ref_len),
  .mute_dac(mute_dac), .zero_adc(zero_adc), .douts_force_low(douts_force_low),
  .locked(locked));

// File: tb/audio_sync_guard_tb_top.sv
`timescale 1ns/1ps
module audio_sync_guard_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lrck = 1'b0;
  logic mute_dac, zero_adc, douts_force_low, locked;
  int n_tests = 0;
  int n_fail = 0;
  bit [1:0] q_exp[$];
  string q_rq[$];
  event samp;

  always #10 clk = ~clk;

  audio_sync_guard dut_i (
    .clk(clk), .rst_n(rst_n), .lrck_in(lrck),
    .mute_dac(mute_dac), .zero_adc(zero_adc),
    .douts_force_low(douts_force_low), .locked(locked));

  task automatic judge(bit m, bit l, string rq);
    n_tests++;
    if (mute_dac !== m || zero_adc !== m || douts_force_low !== m || locked !== l) begin
      n_fail++;
      $display("FAIL %s/R8/R9: mute=%b%b%b locked=%b expected mute=%b locked=%b",
               rq, mute_dac, zero_adc, douts_force_low, locked, m, l);
    end
  endtask

  always begin
    @(samp);
    #1;
    if (q_exp.size() > 0) judge(q_exp[0][1], q_exp[0][0], q_rq[0]);
    void'(q_exp.pop_front());
    void'(q_rq.pop_front());
  end

  task automatic frame(int len, bit m, bit l, string rq);
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      if (c == 0) lrck = 1'b1;
      if (c == len / 2) lrck = 1'b0;
      if (c == 8 || c == len - 2) begin
        q_exp.push_back({m, l});
        q_rq.push_back(rq);
        ->samp;
      end
    end
  endtask

  task automatic run(int n, int len, bit m, bit l, string rq);
    for (int i = 0; i < n; i++) frame(len, m, l, rq);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    judge(1'b1, 1'b0, "R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    judge(1'b1, 1'b0, "R1");

    // R2 acquisition with +-1 BCK spread
    frame(256, 1, 0, "R2");
    frame(260, 1, 0, "R2");
    frame(252, 1, 0, "R2");
    // R4 release countdown: 32 muted locked frames, then release
    run(32, 256, 1, 1, "R4");
    run(2, 256, 0, 1, "R4");

    // R5 tolerated deviations of 5 and 6 BCK, both directions
    frame(276, 0, 1, "R5");
    frame(256, 0, 1, "R5");
    frame(280, 0, 1, "R5");
    frame(256, 0, 1, "R5");
    frame(232, 0, 1, "R5");
    run(2, 256, 0, 1, "R5");

    // R6 deviation of 7 BCK trips
    frame(284, 0, 1, "R6");
    frame(256, 1, 0, "R6");
    // R3 recapture and gap deviation not counted
    frame(256, 1, 0, "R3");
    frame(276, 1, 0, "R3");
    frame(256, 1, 0, "R3");
    frame(256, 1, 0, "R3");
    frame(256, 1, 0, "R3");
    frame(256, 1, 1, "R3");

    // R7 loss during release countdown
    run(4, 256, 1, 1, "R7");
    frame(300, 1, 1, "R7");
    frame(256, 1, 0, "R7");
    frame(256, 1, 0, "R7");
    frame(256, 1, 0, "R7");
    run(32, 256, 1, 1, "R7");
    run(2, 256, 0, 1, "R4");

    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule